// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block holds the software-visible state of a four-channel DMA controller behind a byte-wide I/O port. Each channel keeps a 16-bit current address and a 16-bit current count, with base copies of both. It also keeps a mask bit, a six-bit mode field and a terminal-count flag. The 16-bit values pass through the 8-bit port two bytes at a time. A shared pointer flip-flop picks the low or high half. Software forces that pointer back to the low half with an explicit command.

A count-down engine sits next to the registers. Each acknowledged transfer on an unmasked channel moves the address up by one and the count down by one. Software stores the count as length minus one, so the transfer after the one that finds the count at zero is past the end. That acknowledge marks terminal count. At terminal count the channel either masks itself or, in auto-initialise mode, reloads from its base copies and keeps running. Bus arbitration, memory cycles, page extension and cascading are left to other blocks.

Top module: `chdma_regs`

## Requirements
- R1: After reset every channel is masked (mask_o = 4'hF), every mode field is zero, the byte pointer selects the low byte, and a status read returns request bits in 7:4 and zero in 3:0.
- R2: Port 2n writes channel n's address and port 2n+1 writes its count. Each write stores one byte into both the current and the base copy. The pointer picks the half, low first, and it toggles after every read or write of ports 0x0 to 0x7.
- R3: Any write to port 0xC returns the byte pointer to the low half, whatever the data byte.
- R4: A write to port 0xA selects the channel with data bits 1:0. Data bit 2 set masks that channel and clear unmasks it. Other channels are left as they were.
- R5: A write to port 0xB selects the channel with data bits 1:0 and stores data bits 7:2 as that channel's mode, shown on mode_o[6n+5:6n]. Data bit 4 (mode field bit 2) turns on auto-initialise.
- R6: A read of port 2n or 2n+1 returns the current address or current count. The byte pointer picks the byte, low byte on the first read after a clear, high byte on the next.
- R7: A cycle with dack[n] high on an unmasked channel, and no register write to that channel, adds one to the current address and takes one from the current count at the next edge. On a masked channel dack has no effect.
- R8: When an accepted dack finds the count at zero, tc_o[n] is high in that cycle. At the edge the count wraps to 16'hFFFF, the address still steps up, and the terminal-count flag is set. Without auto-initialise the channel also becomes masked.
- R9: With auto-initialise on, terminal count reloads the current address and count from the base copies and leaves the channel unmasked.
- R10: A read of port 0x8 returns {dreq, terminal-count flags} and clears the flags at that edge. A terminal count that arrives in the same cycle as the read still leaves its flag set.
- R11: A write to port 0xD returns the pointer to the low half, clears all terminal-count flags and masks all four channels. Address and count contents are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Port write strobe |
| rd_en | input | 1 | Port read strobe; side effects take place at the edge |
| port_sel | input | 4 | Port offset |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, combinational from port_sel and state |
| dreq | input | 4 | Per-channel pending request lines, reported in status |
| dack | input | 4 | Per-channel transfer acknowledge |
| tc_o | output | 4 | Terminal count, high during the accepted final acknowledge |
| mask_o | output | 4 | Per-channel mask state, 1 = disabled |
| mode_o | output | 24 | Six mode bits per channel, channel 0 in the low bits |

## Verification
A wrong byte-pointer value appears on the very next address or count access as swapped halves. It then stays wrong until a clear command, so every paired readback in the bench compares both bytes in order. A wrong count or address inside a channel stays hidden until software reads it back. A wrong terminal-count decision shows at once, on tc_o and mask_o. The bench therefore runs channels to their end and reads the registers back just after the final acknowledge. Lost or sticky flags appear on the next status read. Each such read is paired with a second read that must return zero.

// File: rtl/chdma_pkg.sv
package chdma_pkg;
   localparam logic [3:0] PORT_STATUS = 4'h8;
   localparam logic [3:0] PORT_MASK   = 4'hA;
   localparam logic [3:0] PORT_MODE   = 4'hB;
   localparam logic [3:0] PORT_CLRPTR = 4'hC;
   localparam logic [3:0] PORT_MCLR   = 4'hD;
   // position of the auto-initialise bit inside the stored mode field
   localparam int AUTO_BIT = 2;
endpackage

// File: rtl/chdma_bptr.sv
module chdma_bptr (
   input  logic clk,
   input  logic rst_n,
   input  logic toggle,
   input  logic clear,
   output logic ptr_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_hi <= 1'b0;
      else if (clear)  ptr_hi <= 1'b0;
      else if (toggle) ptr_hi <= ~ptr_hi;
   end

   // R3
   ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !ptr_hi);
   // R2
   ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (toggle && !clear) |=> (ptr_hi != $past(ptr_hi)));
endmodule

// File: rtl/chdma_chan.sv
module chdma_chan #(
   parameter int DATA_W = 8,
   parameter int MODE_W = 6,
   localparam int REG_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_byte,
   input  logic              sel_cnt,
   input  logic              ptr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              mask_we,
   input  logic              mask_val,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_d,
   input  logic              mclr,
   input  logic              tc_clr,
   input  logic              dack,
   output logic [REG_W-1:0]  cur_addr,
   output logic [REG_W-1:0]  cur_cnt,
   output logic              mask_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              tc_flag,
   output logic              tc_now
);
   import chdma_pkg::*;

   logic [REG_W-1:0] base_addr, base_cnt;
   logic step, auto_on;

   assign auto_on = mode_q[AUTO_BIT];
   assign step    = dack && !mask_q && !wr_byte;
   assign tc_now  = step && (cur_cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr  <= '0;
         cur_cnt   <= '0;
         base_addr <= '0;
         base_cnt  <= '0;
      end else if (wr_byte) begin
         if (sel_cnt) begin
            if (ptr_hi) begin
               cur_cnt[REG_W-1 -: DATA_W]  <= wdata;
               base_cnt[REG_W-1 -: DATA_W] <= wdata;
            end else begin
               cur_cnt[DATA_W-1:0]  <= wdata;
               base_cnt[DATA_W-1:0] <= wdata;
            end
         end else begin
            if (ptr_hi) begin
               cur_addr[REG_W-1 -: DATA_W]  <= wdata;
               base_addr[REG_W-1 -: DATA_W] <= wdata;
            end else begin
               cur_addr[DATA_W-1:0]  <= wdata;
               base_addr[DATA_W-1:0] <= wdata;
            end
         end
      end else if (tc_now && auto_on) begin
         cur_addr <= base_addr;
         cur_cnt  <= base_cnt;
      end else if (step) begin
         cur_addr <= cur_addr + 1'b1;
         cur_cnt  <= cur_cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= 1'b1;
         mode_q  <= '0;
         tc_flag <= 1'b0;
      end else begin
         if (mclr)                   mask_q <= 1'b1;
         else if (mask_we)           mask_q <= mask_val;
         else if (tc_now && !auto_on) mask_q <= 1'b1;

         if (mode_we) mode_q <= mode_d;

         if (mclr)        tc_flag <= 1'b0;
         else if (tc_now) tc_flag <= 1'b1;
         else if (tc_clr) tc_flag <= 1'b0;
      end
   end

   // R7
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cur_cnt != '0) |=>
         (cur_cnt == $past(cur_cnt) - 1'b1) && (cur_addr == $past(cur_addr) + 1'b1));
   // R7
   masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q && !wr_byte) |=> ($stable(cur_cnt) && $stable(cur_addr)));
   // R8
   tc_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_now && !auto_on && !mask_we) |=> (mask_q && tc_flag && (&cur_cnt)));
   // R9
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_now && auto_on && !mask_we && !mclr) |=>
         (!mask_q && cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr)));
   // R11
   mclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (mask_q && !tc_flag));
endmodule

// File: rtl/chdma_regs.sv
module chdma_regs #(
   parameter int CH_NUM = 4,
   parameter int DATA_W = 8,
   localparam int MODE_W = DATA_W - 2,
   localparam int CH_W   = $clog2(CH_NUM),
   localparam int REG_W  = 2 * DATA_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [3:0]               port_sel,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   input  logic [CH_NUM-1:0]        dreq,
   input  logic [CH_NUM-1:0]        dack,
   output logic [CH_NUM-1:0]        tc_o,
   output logic [CH_NUM-1:0]        mask_o,
   output logic [CH_NUM*MODE_W-1:0] mode_o
);
   import chdma_pkg::*;

   if (CH_NUM != 4) begin : g_bad_ch
      $error("chdma_regs: port map needs CH_NUM == 4");
   end
   if (DATA_W != 2 * CH_NUM) begin : g_bad_w
      $error("chdma_regs: status byte needs DATA_W == 2*CH_NUM");
   end

   logic ptr_hi, reg_acc, ptr_clear, mclr, tc_clr;
   logic [REG_W-1:0] addr_v [CH_NUM];
   logic [REG_W-1:0] cnt_v  [CH_NUM];
   logic [CH_NUM-1:0] tc_flags;

   assign reg_acc   = (wr_en || rd_en) && !port_sel[3];
   assign mclr      = wr_en && (port_sel == PORT_MCLR);
   assign ptr_clear = mclr || (wr_en && (port_sel == PORT_CLRPTR));
   assign tc_clr    = rd_en && !wr_en && (port_sel == PORT_STATUS);

   chdma_bptr u_bptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .toggle (reg_acc),
      .clear  (ptr_clear),
      .ptr_hi (ptr_hi)
   );

   for (genvar g = 0; g < CH_NUM; g++) begin : g_ch
      logic wr_this, mask_this, mode_this;
      assign wr_this   = wr_en && !port_sel[3] && (port_sel[CH_W:1] == CH_W'(g));
      assign mask_this = wr_en && (port_sel == PORT_MASK) && (wdata[CH_W-1:0] == CH_W'(g));
      assign mode_this = wr_en && (port_sel == PORT_MODE) && (wdata[CH_W-1:0] == CH_W'(g));

      chdma_chan #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_byte  (wr_this),
         .sel_cnt  (port_sel[0]),
         .ptr_hi   (ptr_hi),
         .wdata    (wdata),
         .mask_we  (mask_this),
         .mask_val (wdata[2]),
         .mode_we  (mode_this),
         .mode_d   (wdata[DATA_W-1:2]),
         .mclr     (mclr),
         .tc_clr   (tc_clr),
         .dack     (dack[g]),
         .cur_addr (addr_v[g]),
         .cur_cnt  (cnt_v[g]),
         .mask_q   (mask_o[g]),
         .mode_q   (mode_o[g*MODE_W +: MODE_W]),
         .tc_flag  (tc_flags[g]),
         .tc_now   (tc_o[g])
      );
   end

   always_comb begin
      logic [REG_W-1:0] word;
      word  = port_sel[0] ? cnt_v[port_sel[CH_W:1]] : addr_v[port_sel[CH_W:1]];
      rdata = '0;
      if (!port_sel[3])
         rdata = ptr_hi ? word[REG_W-1 -: DATA_W] : word[DATA_W-1:0];
      else if (port_sel == PORT_STATUS)
         rdata = {dreq, tc_flags};
   end

   // R10
   status_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_clr && tc_o == '0) |=> (rdata == '0 || port_sel != PORT_STATUS || dreq != '0 || tc_o != '0 || wr_en));
   // R11
   mclr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (mask_o == '1));
endmodule

// File: tb/chdma_regs_tb.sv
module chdma_regs_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [3:0] port_sel = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] dreq = '0, dack = '0;
   logic [3:0] tc_o, mask_o;
   logic [23:0] mode_o;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   chdma_regs dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
      .dreq(dreq), .dack(dack), .tc_o(tc_o), .mask_o(mask_o), .mode_o(mode_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] p, input logic [7:0] d);
      wr_en = 1'b1; port_sel = p; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] p, output logic [7:0] d);
      rd_en = 1'b1; port_sel = p;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic rd16(input logic [3:0] p, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(p, lo);
      rd(p, hi);
      v = {hi, lo};
   endtask

   task automatic ack(input int ch, output logic [3:0] tc);
      dack[ch] = 1'b1;
      #1 tc = tc_o;
      @(negedge clk);
      dack = '0;
   endtask

   task automatic t_reset;
      logic [7:0] s;
      chk("R1 mask", mask_o, 4'hF);
      chk("R1 mode", mode_o, 24'h0);
      dreq = 4'b1010;
      rd(4'h8, s);
      chk("R1 status", s, 8'hA0);
      dreq = '0;
   endtask

   task automatic t_prog;
      logic [15:0] v;
      wr(4'hC, 8'h00);
      wr(4'h0, 8'h34); wr(4'h0, 8'h12);
      wr(4'h1, 8'h02); wr(4'h1, 8'h00);
      rd16(4'h0, v); chk("R2/R6 ch0 addr", v, 16'h1234);
      rd16(4'h1, v); chk("R2/R6 ch0 count", v, 16'h0002);
   endtask

   task automatic t_clrptr;
      logic [15:0] v;
      wr(4'h2, 8'hAA);
      wr(4'hC, 8'h5A);
      wr(4'h2, 8'hBB); wr(4'h2, 8'hCC);
      wr(4'hC, 8'hFF);
      rd16(4'h2, v); chk("R3 ch1 addr", v, 16'hCCBB);
   endtask

   task automatic t_mask;
      wr(4'hA, 8'h00); chk("R4 unmask ch0", mask_o, 4'hE);
      wr(4'hA, 8'h04); chk("R4 mask ch0", mask_o, 4'hF);
      wr(4'hA, 8'h00); chk("R4 unmask again", mask_o, 4'hE);
   endtask

   task automatic t_mode;
      wr(4'hB, 8'h48); chk("R5 ch0 mode", mode_o[5:0], 6'h12);
      wr(4'hB, 8'h56); chk("R5 ch2 mode", mode_o[17:12], 6'h15);
      chk("R5 ch1 untouched", mode_o[11:6], 6'h00);
   endtask

   task automatic t_step;
      logic [15:0] v; logic [3:0] tc; logic [7:0] s;
      ack(0, tc); chk("R7 no tc", tc, 4'h0);
      wr(4'hC, 8'h00);
      rd16(4'h0, v); chk("R7 addr step", v, 16'h1235);
      rd16(4'h1, v); chk("R7 count step", v, 16'h0001);
      ack(0, tc);
      ack(0, tc); chk("R8 tc_o", tc, 4'h1);
      chk("R8 masked after tc", mask_o, 4'hF);
      rd16(4'h1, v); chk("R8 count wrap", v, 16'hFFFF);
      rd16(4'h0, v); chk("R8 addr", v, 16'h1237);
      rd(4'h8, s); chk("R10 status tc0", s, 8'h01);
      rd(4'h8, s); chk("R10 status cleared", s, 8'h00);
   endtask

   task automatic t_masked;
      logic [15:0] v; logic [3:0] tc;
      ack(1, tc); chk("R7 masked no tc", tc, 4'h0);
      rd16(4'h2, v); chk("R7 masked addr kept", v, 16'hCCBB);
      rd16(4'h3, v); chk("R7 masked count kept", v, 16'h0000);
   endtask

   task automatic t_auto;
      logic [15:0] v; logic [3:0] tc; logic [7:0] s;
      wr(4'h4, 8'h00); wr(4'h4, 8'h01);
      wr(4'h5, 8'h01); wr(4'h5, 8'h00);
      wr(4'hA, 8'h02);
      ack(2, tc);
      ack(2, tc); chk("R9 tc_o", tc, 4'h4);
      chk("R9 stays unmasked", mask_o[2], 1'b0);
      rd16(4'h4, v); chk("R9 addr reload", v, 16'h0100);
      rd16(4'h5, v); chk("R9 count reload", v, 16'h0001);
      rd(4'h8, s); chk("R10 status tc2", s, 8'h04);
      ack(2, tc);
      // status read and terminal count in one cycle
      rd_en = 1'b1; port_sel = 4'h8; dack[2] = 1'b1;
      #1 s = rdata;
      @(negedge clk);
      rd_en = 1'b0; dack = '0;
      chk("R10 read before tc", s, 8'h00);
      rd(4'h8, s); chk("R10 tc kept", s, 8'h04);
   endtask

   task automatic t_mclr;
      logic [7:0] b; logic [15:0] v; logic [3:0] tc;
      ack(2, tc);
      rd(4'h0, b);
      wr(4'hD, 8'h00);
      chk("R11 all masked", mask_o, 4'hF);
      rd16(4'h0, v); chk("R11 ptr low, addr kept", v, 16'h1237);
      rd(4'h8, b); chk("R11 status clear", b, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prog();
      t_clrptr();
      t_mask();
      t_mode();
      t_step();
      t_masked();
      t_auto();
      t_mclr();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule